// File: doc/BRIEF.md
# Duplicate Track Remover

This block sits after a track fitter and removes duplicate candidates from the tracks found in a single road. Tracks come in on a valid/ready stream, one road at a time, and a marker beat ends each road. Each new track is compared at once, in parallel, with every track kept so far for the current road. Two tracks count as duplicates when they share more hits than a programmable limit. Of a duplicate pair, only the one with the better quality survives. Quality ranks the number of layers that carry a hit first and the chi-square second.

When the end-of-road marker is accepted, the block stops taking input. It then sends the surviving tracks, in the order they arrived, on an output valid/ready stream and flags the final one. After that it clears its buffer and accepts the next road. A track of one road is never compared with a track of another road. The per-road buffer has a fixed number of slots. A track that would need a slot after all of them are used is dropped, and an overflow flag is raised for the rest of that road.

Top module: `track_dedup`

## Requirements
- R1: A hit is shared when both tracks have the layer's mask bit set and the same hit index on that layer, counted over 8 layers. The hit index of layer l sits at in_hits[l*6 +: 6]. Two tracks are duplicates only when the shared count is strictly greater than share_limit.
- R2: Tracks of different roads are never compared. A track identical to one in the previous road is kept.
- R3: Of a duplicate pair, the track with more mask bits set ranks higher, whatever the chi-square.
- R4: For duplicates with equal layer counts, the lower chi-square ranks higher. On equal layer count and equal chi-square, the track already kept stays and the new one is dropped.
- R5: A new track that ranks below or equal to any kept duplicate is dropped, and the buffer is left unchanged. A new track that outranks all of its kept duplicates removes every one of them and is appended as the newest entry.
- R6: Each road has 16 buffer slots. Slots are consumed by appends and are not reused within a road. A track that would need a 17th slot is dropped and sets overflow. Overflow stays high until the final track of the road is taken at the output.
- R7: After the end-of-road beat (in_valid with in_eor=1) is accepted, the survivors appear on the output oldest first, starting the next cycle. out_last marks the final one, and the buffer is cleared once that beat is taken.
- R8: in_ready is low while a road is being emitted. While out_valid is high and out_ready is low, the output beat holds unchanged.
- R9: After a synchronous reset, in_ready is 1, out_valid is 0 and overflow is 0.
- R10: A road with no surviving tracks emits nothing. in_ready returns to 1 one cycle after the end-of-road beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_limit | input | 4 | Duplicate threshold on the shared-hit count |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_eor | input | 1 | Beat is an end-of-road marker, not a track |
| in_mask | input | 8 | Layers holding a hit, bit l for layer l |
| in_hits | input | 48 | Hit index per layer, 6 bits each |
| in_chi2 | input | 12 | Fit chi-square, unsigned |
| out_valid | output | 1 | Output track valid |
| out_ready | input | 1 | Downstream takes the output track |
| out_last | output | 1 | Final surviving track of the road |
| out_mask | output | 8 | Layer mask of the output track |
| out_hits | output | 48 | Hit indices of the output track |
| out_chi2 | output | 12 | Chi-square of the output track |
| overflow | output | 1 | Buffer ran out of slots in this road |

## Verification
The comparison is driven with several kinds of track pairs, each aimed at one rule:
- pairs that share exactly the limit and pairs that share one hit more, which separates the strict threshold from an inclusive one;
- pairs whose hit indices match but whose layer masks are disjoint, which shows that masked layers are not counted;
- duplicates that differ only in layer count, only in chi-square, or in nothing at all, which pins down the ranking order and the tie rule;
- a road where one new track overlaps two kept tracks, next to an unrelated one, which shows that all losers are removed and the output order is still arrival order.

A road of 18 tracks that share no hits fills the buffer under output backpressure. The same track sent again as the first track of a new road shows that the buffer does not carry over between roads.

// File: rtl/trkdd_pkg.sv
package trkdd_pkg;

    localparam int LAYERS = 8;
    localparam int HIT_W  = 6;
    localparam int CHI_W  = 12;
    localparam int CNT_W  = $clog2(LAYERS + 1);

    typedef struct packed {
        logic [LAYERS-1:0]            mask;
        logic [LAYERS-1:0][HIT_W-1:0] hit;
        logic [CHI_W-1:0]             chi2;
    } trk_t;

    typedef enum logic {ST_COLLECT, ST_FLUSH} dd_state_e;

    function automatic logic [CNT_W-1:0] layer_count(input logic [LAYERS-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (m[l]) n = n + CNT_W'(1);
        end
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] shared_hits(input trk_t a, input trk_t b);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (a.mask[l] && b.mask[l] && (a.hit[l] == b.hit[l])) n = n + CNT_W'(1);
        end
        return n;
    endfunction

    // true when a strictly outranks b
    function automatic logic outranks(input trk_t a, input trk_t b);
        logic [CNT_W-1:0] la, lb;
        la = layer_count(a.mask);
        lb = layer_count(b.mask);
        return (la > lb) || ((la == lb) && (a.chi2 < b.chi2));
    endfunction

endpackage

// File: rtl/trkdd_cmp.sv
module trkdd_cmp
    import trkdd_pkg::*;
(
    input  trk_t             kept,
    input  logic             kept_vld,
    input  trk_t             cand,
    input  logic [CNT_W-1:0] limit,
    output logic             dup,
    output logic             cand_wins
);
    logic [CNT_W-1:0] n_shared;

    always_comb begin
        n_shared  = shared_hits(kept, cand);
        dup       = kept_vld && (n_shared > limit);
        cand_wins = outranks(cand, kept);
    end
endmodule

// File: rtl/trkdd_pick.sv
module trkdd_pick #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld,
    input  logic [IW-1:0]    start,
    output logic             found,
    output logic [IW-1:0]    idx,
    output logic             more
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        more  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (IW'(i) >= start)) begin
                if (!found) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end else begin
                    more = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/track_dedup.sv
module track_dedup
    import trkdd_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        share_limit,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_eor,
    input  logic [LAYERS-1:0]       in_mask,
    input  logic [LAYERS*HIT_W-1:0] in_hits,
    input  logic [CHI_W-1:0]        in_chi2,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_last,
    output logic [LAYERS-1:0]       out_mask,
    output logic [LAYERS*HIT_W-1:0] out_hits,
    output logic [CHI_W-1:0]        out_chi2,
    output logic                    overflow
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    dd_state_e        st_q;
    trk_t             slot_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PW-1:0]    wr_q;
    logic [IW-1:0]    rd_q;
    logic             ovf_q;

    trk_t             cand, head;
    logic [DEPTH-1:0] dup_v, win_v;
    logic             blocked, full, accept, store, found, more;
    logic [IW-1:0]    pick_idx;

    always_comb begin
        cand.mask = in_mask;
        cand.hit  = in_hits;
        cand.chi2 = in_chi2;
    end

    // one comparator per buffer slot, all evaluated against the incoming track
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        trkdd_cmp u_cmp (
            .kept      (slot_q[g]),
            .kept_vld  (vld_q[g]),
            .cand      (cand),
            .limit     (share_limit),
            .dup       (dup_v[g]),
            .cand_wins (win_v[g])
        );
    end

    trkdd_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
        .vld   (vld_q),
        .start (rd_q),
        .found (found),
        .idx   (pick_idx),
        .more  (more)
    );

    assign in_ready = (st_q == ST_COLLECT);
    assign accept   = in_valid && in_ready;
    assign blocked  = |(dup_v & ~win_v);
    assign full     = (wr_q == PW'(DEPTH));
    assign store    = accept && !in_eor && !blocked && !full;

    assign head      = slot_q[pick_idx];
    assign out_valid = (st_q == ST_FLUSH) && found;
    assign out_last  = !more;
    assign out_mask  = head.mask;
    assign out_hits  = head.hit;
    assign out_chi2  = head.chi2;
    assign overflow  = ovf_q;

    always_ff @(posedge clk) begin
        if (store) slot_q[wr_q[IW-1:0]] <= cand;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_COLLECT;
            vld_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            case (st_q)
                ST_COLLECT: begin
                    if (accept && in_eor) begin
                        st_q <= ST_FLUSH;
                        rd_q <= '0;
                    end else if (accept && !blocked) begin
                        if (full) begin
                            ovf_q <= 1'b1;
                        end else begin
                            vld_q <= (vld_q & ~dup_v) | (DEPTH'(1) << wr_q[IW-1:0]);
                            wr_q  <= wr_q + PW'(1);
                        end
                    end
                end
                default: begin
                    if (!found || (out_ready && !more)) begin
                        st_q  <= ST_COLLECT;
                        vld_q <= '0;
                        wr_q  <= '0;
                        rd_q  <= '0;
                        ovf_q <= 1'b0;
                    end else if (out_ready) begin
                        rd_q <= pick_idx + IW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/track_dedup_chk.sv
module track_dedup_chk
    import trkdd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eor,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [LAYERS-1:0] out_mask,
    input logic [CHI_W-1:0]  out_chi2,
    input logic              overflow
);
    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_chi2) && $stable(out_mask));

    a_r8_no_intake_while_emitting: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r7_reopen_after_last: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

    a_r6_flag_rise_on_track: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(in_valid && in_ready && !in_eor));

    a_r6_flag_clear_on_flush_end: assert property (@(posedge clk) disable iff (rst)
        $fell(overflow) |-> $past(out_valid && out_ready && out_last));
endmodule

bind track_dedup track_dedup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eor    (in_eor),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_mask  (out_mask),
    .out_chi2  (out_chi2),
    .overflow  (overflow)
);

// File: tb/track_dedup_tb_top.sv
module track_dedup_tb_top;
    typedef struct packed {
        logic [7:0]  m;
        logic [47:0] h;
        logic [11:0] c;
    } bt_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  share_limit = 4'd2;
    logic        in_valid = 1'b0, in_eor = 1'b0, out_ready = 1'b0;
    logic [7:0]  in_mask = '0;
    logic [47:0] in_hits = '0;
    logic [11:0] in_chi2 = '0;
    logic        in_ready, out_valid, out_last, overflow;
    logic [7:0]  out_mask;
    logic [47:0] out_hits;
    logic [11:0] out_chi2;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bt_t kept[$];
    bit  m_flush = 0, m_ovf = 0;
    int  m_stored = 0;
    int  rec_c[$];
    int  rec_h7[$];

    always #4 clk = ~clk;

    track_dedup dut_i (
        .clk(clk), .rst(rst), .share_limit(share_limit),
        .in_valid(in_valid), .in_ready(in_ready), .in_eor(in_eor),
        .in_mask(in_mask), .in_hits(in_hits), .in_chi2(in_chi2),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_mask(out_mask), .out_hits(out_hits), .out_chi2(out_chi2),
        .overflow(overflow)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bt_t sel(input logic [7:0] m, input logic [7:0] s,
                                input int a, input int b, input int c);
        bt_t t;
        t.m = m;
        t.c = 12'(c);
        t.h = '0;
        for (int l = 0; l < 8; l++) t.h[l*6 +: 6] = 6'((s[l] ? a : b) + l);
        return t;
    endfunction

    function automatic int n_shared(input bt_t a, input bt_t b);
        int n = 0;
        for (int l = 0; l < 8; l++)
            if (a.m[l] && b.m[l] && a.h[l*6 +: 6] == b.h[l*6 +: 6]) n++;
        return n;
    endfunction

    function automatic bit better(input bt_t a, input bt_t b);
        int la = $countones(a.m);
        int lb = $countones(b.m);
        return (la > lb) || (la == lb && a.c < b.c);
    endfunction

    task automatic model_track(input bt_t t);
        bit blk = 0;
        bit d[$];
        foreach (kept[i]) begin
            d.push_back(n_shared(kept[i], t) > int'(share_limit));
            if (d[i] && !better(t, kept[i])) blk = 1;
        end
        if (blk) return;
        if (m_stored == 16) begin
            m_ovf = 1;
            return;
        end
        for (int i = kept.size() - 1; i >= 0; i--) if (d[i]) kept.delete(i);
        kept.push_back(t);
        m_stored++;
    endtask

    task automatic model_clear();
        m_flush = 0;
        m_stored = 0;
        m_ovf = 0;
    endtask

    // drive one cycle, advance reference model, compare after the edge
    task automatic step(input bit iv, input bit ie, input bt_t t, input bit ordy);
        in_valid = iv; in_eor = ie; in_mask = t.m; in_hits = t.h; in_chi2 = t.c;
        out_ready = ordy;
        if (out_valid && ordy) begin
            rec_c.push_back(int'(out_chi2));
            rec_h7.push_back(int'(out_hits[47:42]));
        end
        if (!m_flush) begin
            if (iv) begin
                if (ie) m_flush = 1;
                else model_track(t);
            end
        end else if (kept.size() == 0) begin
            model_clear();
        end else if (ordy) begin
            void'(kept.pop_front());
            if (kept.size() == 0) model_clear();
        end
        @(negedge clk);
        check("R8 in_ready", in_ready, !m_flush);
        check("R7 out_valid", out_valid, m_flush && kept.size() > 0);
        if (m_flush && kept.size() > 0 && out_valid) begin
            check("R7 out_chi2", out_chi2, kept[0].c);
            check("R7 out_mask", out_mask, kept[0].m);
            check("R7 out_hits", out_hits, kept[0].h);
            check("R7 out_last", out_last, kept.size() == 1);
        end
        check("R6 overflow", overflow, m_ovf);
    endtask

    task automatic send(input bt_t t);
        step(1, 0, t, 0);
    endtask

    task automatic end_road(input bit stall);
        int k = 0;
        rec_c.delete();
        rec_h7.delete();
        step(1, 1, '0, 0);
        while (m_flush && k < 200) begin
            step(0, 0, '0, stall ? ((k % 3) != 0) : 1'b1);
            k++;
        end
        step(0, 0, '0, 0);
    endtask

    task automatic expect_chi(input string tag, input int exp[$]);
        check({tag, " count"}, rec_c.size(), exp.size());
        foreach (exp[i]) if (i < rec_c.size()) check({tag, " chi2 order"}, rec_c[i], exp[i]);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 in_ready", in_ready, 1);
        check("R9 out_valid", out_valid, 0);
        check("R9 overflow", overflow, 0);

        // R1: exactly-at-limit vs one over the limit
        send(sel(8'hFF, 8'hFF, 0, 0, 100));
        send(sel(8'hFF, 8'h03, 0, 20, 90));
        send(sel(8'hFF, 8'h07, 0, 40, 50));
        end_road(0);
        expect_chi("R1 threshold", '{90, 50});

        // R1: identical indices on disjoint masks share nothing
        send(sel(8'h0F, 8'hFF, 0, 0, 10));
        send(sel(8'hF0, 8'hFF, 0, 0, 20));
        end_road(0);
        expect_chi("R1 mask", '{10, 20});

        // R1: higher programmable limit
        share_limit = 4'd7;
        send(sel(8'hFF, 8'hFF, 0, 0, 100));
        send(sel(8'hFF, 8'h7F, 0, 30, 90));
        send(sel(8'hFF, 8'hFF, 0, 0, 80));
        end_road(1);
        expect_chi("R1 limit7", '{90, 80});
        share_limit = 4'd2;

        // R3: fewer layers loses despite lower chi2; R4: lower chi2 wins
        send(sel(8'hFF, 8'hFF, 0, 0, 500));
        send(sel(8'h7F, 8'hFF, 0, 0, 5));
        send(sel(8'hFF, 8'hFF, 0, 0, 400));
        end_road(0);
        expect_chi("R3 R4 ranking", '{400});

        // R4: full tie keeps the earlier track (layer-7 hit 7, not 37)
        send(sel(8'hFF, 8'hFF, 0, 0, 300));
        send(sel(8'hFF, 8'h7F, 0, 30, 300));
        end_road(0);
        expect_chi("R4 tie", '{300});
        if (rec_h7.size() == 1) check("R4 tie keeps earlier", rec_h7[0], 7);

        // R5: one winner replaces two kept duplicates, then a loser is dropped
        send(sel(8'hFF, 8'h0F, 0, 50, 200));
        send(sel(8'hFF, 8'hF0, 0, 60, 220));
        send(sel(8'hFF, 8'h00, 0, 70, 230));
        send(sel(8'hFF, 8'hFF, 0, 0, 150));
        send(sel(8'hFF, 8'h3F, 0, 90, 160));
        end_road(1);
        expect_chi("R5 replace", '{230, 150});

        // R2: same track in the next road is not compared with the previous road
        send(sel(8'hFF, 8'hFF, 0, 0, 100));
        end_road(0);
        send(sel(8'hFF, 8'hFF, 0, 0, 200));
        end_road(0);
        expect_chi("R2 new road", '{200});

        // R10: empty road
        end_road(0);
        expect_chi("R10 empty", '{});
        check("R10 ready again", in_ready, 1);

        // R6: 18 unrelated tracks, 16 stored, overflow until flush ends
        for (int k = 1; k <= 18; k++) send(sel(8'hFF, 8'h00, 0, k, 1000 + k));
        check("R6 overflow raised", overflow, 1);
        end_road(1);
        begin
            int exp[$];
            for (int k = 1; k <= 16; k++) exp.push_back(1000 + k);
            expect_chi("R6 capacity", exp);
        end
        check("R6 overflow cleared", overflow, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule